// File: doc/BRIEF.md
# Four-State Bus Cycle Controller

This block sits between a processor core and an external byte-wide bus. It takes one request at a time (memory read, memory write, I/O read, I/O write or interrupt acknowledge) and runs it as a sequence of whole clock periods named T1, T2, T3 and T4. Wait periods may be inserted between T2 and T3. The low eight address bits share pins with the data, so the address appears there only in T1, and a latch strobe marks that period. The upper address bits have pins of their own.

The requester drives `req_valid` with the operation, address and write data, and holds them steady until `done` pulses. The block accepts a request only at a cycle boundary: while idle, at the end of T4, or when it leaves the bus-hold state. If the requester places its next request during the `done` clock, that request starts in the very next clock. An external master can take the bus by raising `hold`. The block grants the bus with `hlda` only at a cycle boundary, and then keeps every strobe inactive and every shared pin released until `hold` falls.

The operation code carries the fields that the pin decoding depends on. Bit 2 selects interrupt acknowledge, and when it is set the other two bits are ignored. Bit 1 selects I/O space rather than memory. Bit 0 selects write rather than read.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the block is idle. `ale` and `ad_oe` and `a_hi_oe` and `hlda` and `done` are 0. `rd_n`, `wr_n`, `den_n` and `inta_n` are 1. `io_m` and `dt_r` are 0.
- R2: A request seen at a cycle boundary while `hold` is low starts T1 in the next clock. During T1:
  - `ale` is 1, and it is 1 in no other clock.
  - For a non-acknowledge cycle, `ad_oe` is 1 with `ad_out` equal to address bits 7..0, and `a_hi_oe` is 1 with `a_hi` equal to address bits 19..8.
  - `io_m` is op[1] for ordinary cycles and 1 for acknowledge.
  - `dt_r` is 1 only for a write.
  - `den_n`, `rd_n` and `wr_n` are 1.
- R3: From T2 through T3, including any wait periods, `den_n` is 0. A read holds `rd_n` at 0. A write holds `wr_n` at 0 and drives `ad_out` with the write data under `ad_oe`. `rd_n` and `wr_n` are never 0 together.
- R4: `ready` is sampled at the end of T2 and at the end of each wait period. Each low sample adds one wait period, so a cycle lasts 4 plus the number of low samples clocks, counted from T1 through T4.
- R5: The value on `ad_in` at the clock edge that ends T3 appears on `rd_data` during T4. Values present on `ad_in` in earlier periods have no effect.
- R6: In T4, `rd_n`, `wr_n`, `den_n` and `inta_n` are 1 and `ale` and `ad_oe` are 0. `done` is 1 for exactly that one clock.
- R7: An acknowledge cycle (op[2]=1) behaves as follows:
  - In T1 it leaves `ad_oe` and `a_hi_oe` at 0.
  - It holds `inta_n` at 0 from T2 through T3 and returns it to 1 in T4.
  - It never lowers `rd_n` or `wr_n`.
  - It returns the type byte captured at the end of T3 on `rd_data` with `done`.
- R8: `hold` is sampled on every edge but honoured only at a cycle boundary. If `hold` rises inside a cycle, the cycle completes with `hlda` at 0, and `hlda` rises at the edge that ends T4. No cycle starts while `hlda` is 1.
- R9: While `hlda` is 1:
  - `ad_oe` and `a_hi_oe` are 0.
  - `ale` is 0.
  - `rd_n`, `wr_n`, `den_n` and `inta_n` are 1.
- R10: At the first edge that samples `hold` low, `hlda` falls. A request pending at that edge starts T1 in the same clock.
- R11: With `req_valid` low at a boundary the block stays idle and `ale` remains 0. A request present at the end of T4 starts T1 directly in the next clock, with no idle clock between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented; held until `done` |
| req_op | input | 3 | Operation: [2] acknowledge, [1] I/O space, [0] write |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write data |
| ready | input | 1 | Target ready; low inserts wait periods |
| hold | input | 1 | External master asks for the bus |
| ad_in | input | 8 | Shared address/data lines as seen from the bus |
| ad_out | output | 8 | Value driven onto the shared lines |
| ad_oe | output | 1 | Output enable for the shared lines |
| a_hi | output | 12 | Upper address bits 19..8 |
| a_hi_oe | output | 1 | Output enable for the upper address bits |
| ale | output | 1 | Address latch strobe, high in T1 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dt_r | output | 1 | Buffer direction: 1 away from the block, 0 toward it |
| io_m | output | 1 | Space select: 1 I/O, 0 memory |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| hlda | output | 1 | Bus granted to the external master |
| rd_data | output | 8 | Read data or acknowledge type byte |
| done | output | 1 | One-clock pulse in T4 |

## Verification
A wrong phase register shows up at the pins in the same clock. The symptoms are a strobe that is missing or arrives early, `ale` outside T1, or `done` in the wrong clock, so every period of every cycle is compared against the expected pin levels. A wrong wait count moves `done` by whole clocks, and a capture at the wrong edge returns the decoy value that the bench places on `ad_in` before T3. A hold grant made mid-cycle raises `hlda` while the strobes are still active. A grant that is never released stops the next request from ever reaching T1.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  localparam int OP_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5,
    PH_HELD = 3'd6
  } phase_e;

  // op[2] acknowledge, op[1] I/O space, op[0] write
  function automatic logic op_is_ack(input logic [OP_W-1:0] op);
    return op[2];
  endfunction

  function automatic logic op_is_write(input logic [OP_W-1:0] op);
    return !op[2] && op[0];
  endfunction

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return !op[2] && !op[0];
  endfunction

  function automatic logic op_space_io(input logic [OP_W-1:0] op);
    return op[2] || op[1];
  endfunction

endpackage

// File: rtl/bcc_sequencer.sv
module bcc_sequencer
  import bcc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   ready,
  input  logic   hold,
  output phase_e phase,
  output logic   at_boundary,
  output logic   start_cycle,
  output logic   wait_ins,
  output logic   sample_pt
);

  phase_e phase_nx;

  assign at_boundary = (phase == PH_IDLE) || (phase == PH_T4) || (phase == PH_HELD);
  assign start_cycle = at_boundary && !hold && req_valid;
  assign wait_ins    = ((phase == PH_T2) || (phase == PH_TW)) && !ready;
  assign sample_pt   = (phase == PH_T3);

  always_comb begin
    phase_nx = PH_IDLE;
    case (phase)
      PH_IDLE, PH_T4, PH_HELD: begin
        if (hold)           phase_nx = PH_HELD;
        else if (req_valid) phase_nx = PH_T1;
        else                phase_nx = PH_IDLE;
      end
      PH_T1:        phase_nx = PH_T2;
      PH_T2, PH_TW: phase_nx = ready ? PH_T3 : PH_TW;
      PH_T3:        phase_nx = PH_T4;
      default:      phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

endmodule

// File: rtl/bcc_req_latch.sv
module bcc_req_latch
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cycle,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [OP_W-1:0]   op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_cycle) begin
      op_q    <= req_op;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

endmodule

// File: rtl/bcc_capture.sv
module bcc_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_pt,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_data <= '0;
    else if (sample_pt) rd_data <= ad_in;
  end

endmodule

// File: rtl/bcc_pin_drive.sv
module bcc_pin_drive
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  phase_e                   phase,
  input  logic [OP_W-1:0]          op_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [DATA_W-1:0]        wdata_q,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     a_hi_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     den_n,
  output logic                     dt_r,
  output logic                     io_m,
  output logic                     inta_n,
  output logic                     hlda,
  output logic                     done
);

  logic in_cycle;
  logic strobe_win;
  logic held;

  assign in_cycle   = (phase == PH_T1) || (phase == PH_T2) || (phase == PH_TW) ||
                      (phase == PH_T3) || (phase == PH_T4);
  assign strobe_win = (phase == PH_T2) || (phase == PH_TW) || (phase == PH_T3);
  assign held       = (phase == PH_HELD);

  assign ale     = (phase == PH_T1);
  assign rd_n    = !(strobe_win && op_is_read(op_q));
  assign wr_n    = !(strobe_win && op_is_write(op_q));
  assign inta_n  = !(strobe_win && op_is_ack(op_q));
  assign den_n   = !strobe_win;
  assign ad_oe   = ((phase == PH_T1) && !op_is_ack(op_q)) ||
                   (strobe_win && op_is_write(op_q));
  assign ad_out  = (phase == PH_T1) ? addr_q[DATA_W-1:0] : wdata_q;
  assign a_hi    = addr_q[ADDR_W-1:DATA_W];
  assign a_hi_oe = in_cycle && !op_is_ack(op_q);
  assign io_m    = !held && op_space_io(op_q);
  assign dt_r    = !held && op_is_write(op_q);
  assign hlda    = held;
  assign done    = (phase == PH_T4);

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [2:0]               req_op,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     ready,
  input  logic                     hold,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic                     a_hi_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     den_n,
  output logic                     dt_r,
  output logic                     io_m,
  output logic                     inta_n,
  output logic                     hlda,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     done
);

  phase_e            phase;
  logic              at_boundary;
  logic              start_cycle;
  logic              wait_ins;
  logic              sample_pt;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  bcc_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .ready       (ready),
    .hold        (hold),
    .phase       (phase),
    .at_boundary (at_boundary),
    .start_cycle (start_cycle),
    .wait_ins    (wait_ins),
    .sample_pt   (sample_pt)
  );

  bcc_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lat (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_cycle (start_cycle),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .op_q        (op_q),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q)
  );

  bcc_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_pt (sample_pt),
    .ad_in     (ad_in),
    .rd_data   (rd_data)
  );

  bcc_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .phase   (phase),
    .op_q    (op_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .a_hi    (a_hi),
    .a_hi_oe (a_hi_oe),
    .ale     (ale),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .den_n   (den_n),
    .dt_r    (dt_r),
    .io_m    (io_m),
    .inta_n  (inta_n),
    .hlda    (hlda),
    .done    (done)
  );

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker
  import bcc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic [DATA_W-1:0] ad_in,
  input logic              ad_oe,
  input logic              a_hi_oe,
  input logic              ale,
  input logic              rd_n,
  input logic              wr_n,
  input logic              den_n,
  input logic              inta_n,
  input logic              hlda,
  input logic [DATA_W-1:0] rd_data,
  input logic              done,
  input phase_e            phase,
  input logic              at_boundary,
  input logic              start_cycle,
  input logic              wait_ins,
  input logic              sample_pt
);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R4
  wait_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ins |=> (phase == PH_TW));

  // R4
  ready_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_T2) && ready) |=> (phase == PH_T3));

  // R5
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |=> (rd_data == $past(ad_in)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rd_n && wr_n && den_n && inta_n && !ale && !ad_oe));

  // R8
  grant_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(at_boundary));

  // R8
  no_start_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && start_cycle) |=> !hlda);

  // R9
  held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (!ad_oe && !a_hi_oe && !ale && rd_n && wr_n && den_n && inta_n));

endmodule

bind bus_cycle_ctrl bcc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready       (ready),
  .ad_in       (ad_in),
  .ad_oe       (ad_oe),
  .a_hi_oe     (a_hi_oe),
  .ale         (ale),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .den_n       (den_n),
  .inta_n      (inta_n),
  .hlda        (hlda),
  .rd_data     (rd_data),
  .done        (done),
  .phase       (phase),
  .at_boundary (at_boundary),
  .start_cycle (start_cycle),
  .wait_ins    (wait_ins),
  .sample_pt   (sample_pt)
);

// File: tb/sim_bus_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_bus_cycle_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata;
  logic        ready;
  logic        hold;
  logic [7:0]  ad_in;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [11:0] a_hi;
  logic        a_hi_oe;
  logic        ale, rd_n, wr_n, den_n, dt_r, io_m, inta_n, hlda, done;
  logic [7:0]  rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_cycle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .hold(hold),
    .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
    .a_hi_oe(a_hi_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
    .dt_r(dt_r), .io_m(io_m), .inta_n(inta_n), .hlda(hlda),
    .rd_data(rd_data), .done(done)
  );

  // Expected decoding, restated from the requirement text.
  function automatic logic e_ack(input logic [2:0] op);   return op[2] == 1'b1; endfunction
  function automatic logic e_wr(input logic [2:0] op);    return (op[2] == 1'b0) && (op[0] == 1'b1); endfunction
  function automatic logic e_rd(input logic [2:0] op);    return (op[2] == 1'b0) && (op[0] == 1'b0); endfunction
  function automatic logic e_space(input logic [2:0] op); return e_ack(op) ? 1'b1 : op[1]; endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " ad_oe"}, ad_oe, 0);
    chk({tag, " a_hi_oe"}, a_hi_oe, 0);
    chk({tag, " ale"}, ale, 0);
    chk({tag, " strobes"}, {rd_n, wr_n, den_n, inta_n}, 4'hF);
  endtask

  task automatic chk_strobe(input logic [2:0] op, input logic [7:0] wd);
    chk("R3 den_n", den_n, 0);
    chk("R3 rd_n", rd_n, !e_rd(op));
    chk("R3 wr_n", wr_n, !e_wr(op));
    chk("R7 inta_n", inta_n, !e_ack(op));
    chk("R2 ale off", ale, 0);
    chk("R6 done early", done, 0);
    chk("R8 hlda mid", hlda, 0);
    if (e_wr(op)) begin
      chk("R3 ad_oe wr", ad_oe, 1);
      chk("R3 wdata", ad_out, wd);
    end else begin
      chk("R3 ad_oe rd", ad_oe, 0);
    end
  endtask

  task automatic set_req(input logic [2:0] op, input logic [19:0] addr, input logic [7:0] wd);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = addr;
    req_wdata = wd;
  endtask

  // Called at the negedge inside T1; returns at the negedge inside T4.
  task automatic run_body(input logic [2:0] op, input logic [19:0] addr, input logic [7:0] wd,
                          input int nw, input logic [7:0] rv, input bit hold_mid);
    chk("R2 ale T1", ale, 1);
    chk("R2 io_m", io_m, e_space(op));
    chk("R2 dt_r", dt_r, e_wr(op));
    chk("R2 strobes T1", {rd_n, wr_n, den_n}, 3'b111);
    chk("R2 done T1", done, 0);
    if (e_ack(op)) begin
      chk("R7 ad float", ad_oe, 0);
      chk("R7 a_hi float", a_hi_oe, 0);
    end else begin
      chk("R2 ad_oe", ad_oe, 1);
      chk("R2 addr lo", ad_out, addr[7:0]);
      chk("R2 a_hi_oe", a_hi_oe, 1);
      chk("R2 addr hi", a_hi, addr[19:8]);
    end
    ad_in = ~rv;
    tick(); // T2
    chk_strobe(op, wd);
    ready = (nw == 0);
    if (hold_mid) hold = 1'b1;
    for (int i = 0; i < nw; i++) begin
      tick(); // wait period
      chk_strobe(op, wd);
      ad_in = rv ^ 8'h5A;
      ready = (i == nw - 1);
    end
    tick(); // T3
    chk_strobe(op, wd);
    ad_in = rv;
    ready = 1'b1;
    tick(); // T4
    chk("R4 R6 done in T4", done, 1);
    chk("R6 release", {rd_n, wr_n, den_n, inta_n}, 4'hF);
    chk("R6 ale", ale, 0);
    chk("R6 ad_oe", ad_oe, 0);
    if (!e_wr(op)) chk(e_ack(op) ? "R7 type byte" : "R5 rd_data", rd_data, rv);
    req_valid = 1'b0;
    ad_in = 8'h00;
  endtask

  task automatic do_cycle(input logic [2:0] op, input logic [19:0] addr, input logic [7:0] wd,
                          input int nw, input logic [7:0] rv, input bit hold_mid);
    set_req(op, addr, wd);
    tick(); // T1
    run_body(op, addr, wd, nw, rv, hold_mid);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
    ready = 1'b1; hold = 1'b0; ad_in = '0;
    void'($urandom(32'h0BC5_2207));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ale", ale, 0);
    chk("R1 oe", {ad_oe, a_hi_oe}, 0);
    chk("R1 strobes", {rd_n, wr_n, den_n, inta_n}, 4'hF);
    chk("R1 hlda/done", {hlda, done}, 0);
    chk("R1 io_m/dt_r", {io_m, dt_r}, 0);
    // R11 no request, stays idle
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R11 idle ale", ale, 0);
      chk("R11 idle done", done, 0);
    end

    // Directed cycles, back to back (R11)
    do_cycle(3'b000, 20'hA8E24, 8'h00, 0, 8'h3C, 0); // mem read
    do_cycle(3'b011, 20'h00079, 8'hC7, 2, 8'h11, 0); // io write, 2 waits
    do_cycle(3'b100, 20'hFFFFF, 8'h00, 1, 8'h20, 0); // acknowledge
    do_cycle(3'b001, 20'h17000, 8'h34, 0, 8'h99, 0); // mem write
    do_cycle(3'b010, 20'h02028, 8'h00, 5, 8'hE7, 0); // io read, 5 waits
    do_cycle(3'b111, 20'h12345, 8'hAA, 0, 8'h08, 0); // acknowledge, other bits set
    tick();
    chk("R11 idle after", ale, 0);

    // Hold while idle, request waits
    hold = 1'b1;
    tick();
    chk("R8 grant idle", hlda, 1);
    chk_quiet("R9 held");
    set_req(3'b000, 20'h24800, 8'h00);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8 no start held", ale, 0);
      chk("R8 still held", hlda, 1);
      chk_quiet("R9 held req");
    end
    hold = 1'b0;
    tick();
    chk("R10 hlda drop", hlda, 0);
    run_body(3'b000, 20'h24800, 8'h00, 1, 8'h07, 0);

    // Hold raised inside a cycle
    do_cycle(3'b001, 20'h06090, 8'h20, 2, 8'h00, 1);
    tick();
    chk("R8 grant after T4", hlda, 1);
    chk_quiet("R9 held mid");
    hold = 1'b0;
    tick();
    chk("R10 release", hlda, 0);
    chk("R11 no req after hold", ale, 0);

    // Constrained random cycles
    for (int k = 0; k < 60; k++) begin
      logic [2:0]  op;
      logic [19:0] ad;
      logic [7:0]  wd, rv;
      int          nw;
      op = 3'($urandom % 8);
      ad = 20'($urandom);
      wd = 8'($urandom);
      rv = 8'($urandom);
      nw = int'($urandom % 4);
      do_cycle(op, ad, wd, nw, rv, 0);
      if (($urandom % 3) == 0) begin
        tick();
        chk("R11 gap idle", ale, 0);
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule